// File: doc/BRIEF.md
# Dynamic Predication Fetch Controller

This front-end controller decides when fetch switches into dynamic predication mode and when it returns to normal operation. Each decoded branch arrives with a two-bit diverge marker, a signed merge offset and a confidence bit from an outside estimator.

When a diverge branch is marked low confidence, the controller does the following:
- It records the merge-point address.
- It takes the lowest free predicate id.
- It pulses a fork request, which tells the return stack, global history and rename alias table to fork.
- It then alternates fetch between the predicted path (path 0) and the alternate path (path 1).

A path that fetches the merge address stops there, and the other path gets every fetch slot from then on. Predication mode ends for one of four reasons:
- both paths have reached the merge point;
- the diverge branch resolves;
- a path fetches more than a programmable number of instructions before it merges;
- a younger low-confidence diverge branch on the predicted path takes over.

In the last case the controller leaves the mode and enters it again for the younger branch in the same cycle. Predicate ids stay allocated until the pipeline returns them through the release port.

Top module: `dpred_fetch_ctl`

## Requirements
- R1: After reset, `pred_mode`, `fork_pulse`, `exit_pulse` and `fetch_path` are all 0.
- R2: A branch enters the mode only if it has `br_lowconf`=1 and one of these markers: marker 2'b10 (forward diverge), or marker 2'b11 (loop diverge) with `br_pred_exit`=1. Marker 2'b00, and any branch with `br_lowconf`=0, leaves the controller unchanged. On entry, `fork_pulse` is 1 for the cycle after the branch.
- R3: On entry, `cfm_addr` becomes `br_pc` plus `br_ofs`, with `br_ofs` sign-extended to the address width and the sum taken modulo 2^ADDR_W.
- R4: On entry, `pred_id` is the lowest-numbered id that is not allocated.
- R5: Fetch starts on path 0. While neither path has merged, `fetch_path` flips after every fetched instruction.
- R6: When a fetch on the current path has `f_pc` equal to `cfm_addr`, that path is finished, and `fetch_path` stays on the other path.
- R7: When the second path also reaches `cfm_addr`, the controller leaves the mode with `exit_pulse`=1 and `exit_cause`=0.
- R8: A resolve with `res_id` equal to `pred_id` ends the mode with `exit_cause`=1. A resolve with any other id has no effect.
- R9: When a path's count of non-merge fetches since entry would exceed `thresh`, the mode ends with `exit_cause`=2. That happens on the fetch numbered `thresh`+1.
- R10: In the mode, a qualifying branch with `br_path`=0 raises `exit_pulse` with `exit_cause`=3 and re-enters the mode, with a new `cfm_addr`, a new `pred_id` and a new `fork_pulse`. With `br_path`=1 such a branch is ignored.
- R11: If every predicate id is allocated, a qualifying branch does not enter the mode. A `rel_valid` pulse makes `rel_id` free again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh | input | CNT_W | Limit on per-path fetches before the mode is abandoned |
| br_valid | input | 1 | A decoded branch is present |
| br_kind | input | 2 | Diverge marker: 00 normal, 10 forward diverge, 11 loop diverge |
| br_pc | input | ADDR_W | Branch address |
| br_ofs | input | OFS_W | Signed offset from the branch address to the merge point |
| br_lowconf | input | 1 | Estimator flags the branch as low confidence |
| br_pred_exit | input | 1 | A loop branch is predicted to leave the loop |
| br_path | input | 1 | Path that fetched the branch: 0 predicted, 1 alternate |
| f_valid | input | 1 | One instruction was fetched on `fetch_path` |
| f_pc | input | ADDR_W | Address of that instruction |
| res_valid | input | 1 | A diverge branch has resolved |
| res_id | input | PID_W | Predicate id of the resolved branch |
| rel_valid | input | 1 | Return a predicate id |
| rel_id | input | PID_W | Id being returned |
| pred_mode | output | 1 | Dynamic predication mode is active |
| cfm_addr | output | ADDR_W | Merge-point address |
| pred_id | output | PID_W | Predicate id of the current episode |
| fork_pulse | output | 1 | Fork the return stack, history and alias table |
| fetch_path | output | 1 | Path that fetches next |
| exit_pulse | output | 1 | The mode ended this cycle |
| exit_cause | output | 2 | Why it ended: 0 merged, 1 resolved, 2 count limit, 3 yield |

## Verification
The assertions check these on every cycle:
- a fork never occurs outside the mode, and it always starts on path 0 with neither path merged;
- once one path is finished, fetch never picks it again;
- an exit is only reported from inside the mode;
- a high-confidence branch seen while idle never causes a fork.

Some behaviour depends on sequences of events, and only the bench scenarios show it:
- the sign-extended merge address;
- lowest-free id selection and running out of ids;
- the exact fetch on which the count limit fires, checked across a sweep of thresholds;
- yield re-entry, and which resolve ids match.

// File: rtl/dpred_fetch_ctl.sv
module dpred_fetch_ctl #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 8,
  parameter int PID_W  = 2,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  thresh,
  input  logic              br_valid,
  input  logic [1:0]        br_kind,
  input  logic [ADDR_W-1:0] br_pc,
  input  logic [OFS_W-1:0]  br_ofs,
  input  logic              br_lowconf,
  input  logic              br_pred_exit,
  input  logic              br_path,
  input  logic              f_valid,
  input  logic [ADDR_W-1:0] f_pc,
  input  logic              res_valid,
  input  logic [PID_W-1:0]  res_id,
  input  logic              rel_valid,
  input  logic [PID_W-1:0]  rel_id,
  output logic              pred_mode,
  output logic [ADDR_W-1:0] cfm_addr,
  output logic [PID_W-1:0]  pred_id,
  output logic              fork_pulse,
  output logic              fetch_path,
  output logic              exit_pulse,
  output logic [1:0]        exit_cause
);
  localparam int NPID = 1 << PID_W;

  logic [NPID-1:0]  busy;
  logic [1:0]       done;
  logic [CNT_W-1:0] cnt [2];

  logic             have_free;
  logic [PID_W-1:0] free_id;
  always_comb begin
    have_free = 1'b0;
    free_id   = '0;
    for (int i = NPID - 1; i >= 0; i--)
      if (!busy[i]) begin
        have_free = 1'b1;
        free_id   = i[PID_W-1:0];
      end
  end

  wire qual    = br_valid && br_kind[1] && br_lowconf && (!br_kind[0] || br_pred_exit);
  wire enter   = qual && have_free && (!pred_mode || !br_path);
  wire res_hit = pred_mode && res_valid && (res_id == pred_id);
  wire fv      = pred_mode && f_valid;
  wire at_cfm  = (f_pc == cfm_addr);
  wire [CNT_W:0] cnt_inc = {1'b0, cnt[fetch_path]} + 1'b1;
  wire over    = fv && !at_cfm && (cnt_inc > {1'b0, thresh});
  wire [1:0] nx_done = done | ((fv && at_cfm) ? (fetch_path ? 2'b10 : 2'b01) : 2'b00);
  wire merged  = pred_mode && (&nx_done);
  wire leaving = pred_mode && (res_hit || enter || over || merged);

  logic [1:0] cause;
  always_comb begin
    if (res_hit)    cause = 2'd1;
    else if (enter) cause = 2'd3;
    else if (over)  cause = 2'd2;
    else            cause = 2'd0;
  end

  logic nx_sel;
  always_comb begin
    if (nx_done == 2'b01)      nx_sel = 1'b1;
    else if (nx_done == 2'b10) nx_sel = 1'b0;
    else if (fv)               nx_sel = ~fetch_path;
    else                       nx_sel = fetch_path;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_mode  <= 1'b0;
      cfm_addr   <= '0;
      pred_id    <= '0;
      fork_pulse <= 1'b0;
      fetch_path <= 1'b0;
      exit_pulse <= 1'b0;
      exit_cause <= 2'd0;
      busy       <= '0;
      done       <= 2'b00;
      cnt[0]     <= '0;
      cnt[1]     <= '0;
    end else begin
      fork_pulse <= enter;
      exit_pulse <= leaving;
      if (leaving) exit_cause <= cause;
      if (rel_valid) busy[rel_id] <= 1'b0;
      if (enter) begin
        pred_mode     <= 1'b1;
        cfm_addr      <= br_pc + {{(ADDR_W-OFS_W){br_ofs[OFS_W-1]}}, br_ofs};
        pred_id       <= free_id;
        busy[free_id] <= 1'b1;
        fetch_path    <= 1'b0;
        done          <= 2'b00;
        cnt[0]        <= '0;
        cnt[1]        <= '0;
      end else if (leaving) begin
        pred_mode  <= 1'b0;
        fetch_path <= 1'b0;
        done       <= 2'b00;
      end else if (pred_mode) begin
        done       <= nx_done;
        fetch_path <= nx_sel;
        if (fv && !at_cfm) cnt[fetch_path] <= cnt_inc[CNT_W-1:0];
      end
    end
  end

  a_r4_fork_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
    fork_pulse |-> pred_mode && busy[pred_id]);
  a_r5_fork_starts_path0: assert property (@(posedge clk) disable iff (!rst_n)
    fork_pulse |-> !fetch_path && done == 2'b00);
  a_r6_done0_sel1: assert property (@(posedge clk) disable iff (!rst_n)
    pred_mode && done == 2'b01 |-> fetch_path);
  a_r6_done1_sel0: assert property (@(posedge clk) disable iff (!rst_n)
    pred_mode && done == 2'b10 |-> !fetch_path);
  a_r7_exit_from_mode: assert property (@(posedge clk) disable iff (!rst_n)
    exit_pulse |-> $past(pred_mode));
  a_r2_highconf_idle: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && !br_lowconf && !pred_mode |=> !fork_pulse);
endmodule

// File: tb/dpred_fetch_ctl_bench.sv
module dpred_fetch_ctl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  thresh = 8'd10;
  logic        br_valid = 0, br_lowconf = 0, br_pred_exit = 0, br_path = 0;
  logic [1:0]  br_kind = 0;
  logic [15:0] br_pc = 0, f_pc = 0;
  logic [7:0]  br_ofs = 0;
  logic        f_valid = 0, res_valid = 0, rel_valid = 0;
  logic [1:0]  res_id = 0, rel_id = 0;
  logic        pred_mode, fork_pulse, fetch_path, exit_pulse;
  logic [15:0] cfm_addr;
  logic [1:0]  pred_id, exit_cause;

  int total = 0, bad = 0;
  bit finished = 0;

  dpred_fetch_ctl u_dpred_fetch_ctl (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic branch(input logic [1:0] k, input logic [15:0] pc, input logic [7:0] ofs,
                        input logic lc, input logic pe, input logic pth);
    br_valid = 1; br_kind = k; br_pc = pc; br_ofs = ofs;
    br_lowconf = lc; br_pred_exit = pe; br_path = pth;
    step();
    br_valid = 0;
  endtask

  task automatic fetch(input logic [15:0] pc);
    f_valid = 1; f_pc = pc; step(); f_valid = 0;
  endtask

  task automatic resolve(input logic [1:0] id);
    res_valid = 1; res_id = id; step(); res_valid = 0;
  endtask

  task automatic release_id(input logic [1:0] id);
    rel_valid = 1; rel_id = id; step(); rel_valid = 0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1; step();
    chk("R1 mode", pred_mode, 0);
    chk("R1 fork", fork_pulse, 0);
    chk("R1 exit", exit_pulse, 0);
    chk("R1 path", fetch_path, 0);

    // R2/R3/R4/R8 sweep over marker, confidence and loop-exit prediction
    for (int i = 0; i < 16; i++) begin
      logic [1:0] k;
      logic lc, pe, want;
      logic [15:0] pc;
      logic [7:0] ofs;
      k = i[3:2]; lc = i[1]; pe = i[0];
      pc = 16'h0100 + 16'(i * 8);
      ofs = 8'(i * 37 - 128);
      want = k[1] && lc && (!k[0] || pe);
      branch(k, pc, ofs, lc, pe, 0);
      chk("R2 fork", fork_pulse, int'(want));
      chk("R2 mode", pred_mode, int'(want));
      if (want) begin
        chk("R3 cfm", cfm_addr, int'(16'(pc + {{8{ofs[7]}}, ofs})));
        chk("R4 pid", pred_id, 0);
        step();
        chk("R2 fork one cycle", fork_pulse, 0);
        resolve(2'd3);
        chk("R8 wrong id ignored", pred_mode, 1);
        resolve(2'd0);
        chk("R8 exit", exit_pulse, 1);
        chk("R8 cause", exit_cause, 1);
        chk("R8 mode off", pred_mode, 0);
        release_id(2'd0);
      end
    end

    // R5/R6/R7 round-robin and merge
    thresh = 8'd10;
    branch(2'b10, 16'h0200, 8'h20, 1, 0, 0);
    chk("R5 start path0", fetch_path, 0);
    fetch(16'h0204); chk("R5 toggle", fetch_path, 1);
    fetch(16'h0300); chk("R5 toggle back", fetch_path, 0);
    fetch(16'h0220); chk("R6 switch to path1", fetch_path, 1);
    chk("R6 no exit yet", exit_pulse, 0);
    fetch(16'h0304); chk("R6 stay path1", fetch_path, 1);
    fetch(16'h0308); chk("R6 stay path1 again", fetch_path, 1);
    chk("R6 still mode", pred_mode, 1);
    fetch(16'h0220);
    chk("R7 exit", exit_pulse, 1);
    chk("R7 cause", exit_cause, 0);
    chk("R7 mode off", pred_mode, 0);
    release_id(2'd0);

    // R9 counter threshold sweep
    for (int t = 1; t <= 6; t++) begin
      thresh = 8'(t);
      branch(2'b11, 16'h0400, 8'h40, 1, 1, 0);
      fetch(16'h0500);
      fetch(16'h0440);
      chk("R9 path1 merged, path0 owns fetch", fetch_path, 0);
      for (int n = 2; n <= t + 1; n++) begin
        fetch(16'h0500 + 16'(n * 4));
        if (n <= t) chk("R9 below limit", pred_mode, 1);
        else begin
          chk("R9 exit", exit_pulse, 1);
          chk("R9 cause", exit_cause, 2);
          chk("R9 mode off", pred_mode, 0);
        end
      end
      release_id(2'd0);
    end

    // R10 yield
    thresh = 8'd10;
    branch(2'b10, 16'h0600, 8'h10, 1, 0, 0);
    step();
    branch(2'b10, 16'h0700, 8'h08, 1, 0, 1);
    chk("R10 alt path ignored fork", fork_pulse, 0);
    chk("R10 alt path ignored cfm", cfm_addr, 16'h0610);
    branch(2'b10, 16'h0700, 8'h08, 1, 0, 0);
    chk("R10 exit", exit_pulse, 1);
    chk("R10 cause", exit_cause, 3);
    chk("R10 refork", fork_pulse, 1);
    chk("R10 mode", pred_mode, 1);
    chk("R10 cfm", cfm_addr, 16'h0708);
    chk("R10 pid", pred_id, 1);
    resolve(2'd1);
    release_id(2'd0);
    release_id(2'd1);

    // R11 pid exhaustion
    for (int j = 0; j < 4; j++) begin
      branch(2'b10, 16'h0800, 8'h10, 1, 0, 0);
      chk("R4 sequential pid", pred_id, j);
      resolve(2'(j));
    end
    branch(2'b10, 16'h0800, 8'h10, 1, 0, 0);
    chk("R11 no free fork", fork_pulse, 0);
    chk("R11 no free mode", pred_mode, 0);
    release_id(2'd2);
    branch(2'b10, 16'h0800, 8'h10, 1, 0, 0);
    chk("R11 freed id reused", pred_id, 2);
    chk("R11 mode", pred_mode, 1);
    resolve(2'd2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule